// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Register

This block is the serial test port of a chip. It is clocked by the test clock `tck`. On every rising edge it steps a sixteen-state controller according to the mode-select input `tms`. It owns an instruction register that is loaded through the instruction path. Capture loads a fixed check pattern, shift brings in a new code from `tdi`, and update makes that code the active instruction.

The active instruction picks one data register. Codes below `NUM_DR` pick one of the external data registers. Every other code, including the all-ones code loaded on reset, picks a one-bit bypass stage held inside the block. For the external registers, the block provides capture, shift and update strobes, and it takes in one serial output per register. The serial output `tdo` changes on the falling edge of `tck`. It carries data only while a shift state is active, which `tdo_oe` signals.

Top module: `tap_port`

## Requirements
- R1: From Test-Logic-Reset (0xF), tms=1 stays there and tms=0 moves to Run-Test/Idle (0xC). Run-Test/Idle holds on tms=0 and moves to Select-DR (0x7) on tms=1. Select-DR goes to Capture-DR (0x6) on 0 and to Select-IR (0x4) on 1. Select-IR goes to Capture-IR (0xE) on 0 and back to 0xF on 1.
- R2: Five consecutive rising edges of `tck` with tms=1 leave the controller in Test-Logic-Reset, whatever state it started from.
- R3: `trst_n` sampled low at a rising edge puts the controller in Test-Logic-Reset and makes the all-ones instruction active at that same edge. At a falling edge it also clears `tdo_oe`.
- R4: On each path, state codes are DR/IR: Capture 0x6/0xE, Shift 0x2/0xA, Exit1 0x1/0x9, Pause 0x3/0xB, Exit2 0x0/0x8, Update 0x5/0xD. The transitions are:
  - Capture goes to Shift on 0 and to Exit1 on 1.
  - Shift holds on 0 and goes to Exit1 on 1.
  - Exit1 goes to Pause on 0 and to Update on 1.
  - Pause holds on 0 and goes to Exit2 on 1.
  - Exit2 goes back to Shift on 0 and to Update on 1.
  - Update goes to Run-Test/Idle on 0 and to Select-DR on 1.
- R5: Capture-IR loads the pattern 4'b0001 into the instruction shift stage. Each Shift-IR edge moves `tdi` into the top bit and shifts toward bit 0. `tdo` presents bit 0, so the pattern leaves LSB first.
- R6: The active instruction `insn` changes only at an edge taken in Update-IR, where it takes the shifted value, or in Test-Logic-Reset, where it becomes all ones.
- R7: Active code k < NUM_DR sets only bit k of `dr_sel`, and `tdo` carries `dr_tdo[k]` in Shift-DR. Any other code leaves `dr_sel` zero and selects the bypass stage.
- R8: The bypass stage loads 0 at a Capture-DR edge and takes `tdi` at each Shift-DR edge, so it delays data by one bit.
- R9: `dr_capture`, `dr_shift` and `dr_update` are high exactly while the state is Capture-DR, Shift-DR and Update-DR respectively.
- R10: `tdo` and `tdo_oe` update on the falling edge of `tck`. `tdo_oe` is high exactly when the state is Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on clock edges |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| dr_tdo | input | NUM_DR | Serial outputs of the external data registers |
| tdo | output | 1 | Serial data out, falling-edge registered |
| tdo_oe | output | 1 | Output enable for `tdo` |
| dr_sel | output | NUM_DR | One-hot select of the external data register |
| dr_capture | output | 1 | Capture strobe for the selected data register |
| dr_shift | output | 1 | Shift strobe for the selected data register |
| dr_update | output | 1 | Update strobe for the selected data register |
| insn | output | IR_W | Active instruction |
| tap_state | output | 4 | Controller state code |

## Verification
The bench uses the default build: a 4-bit instruction register, capture pattern 0001, and four external data registers. With these values, codes 0 to 3 reach external registers and the other twelve codes fall to bypass. Random shifts of `tdi` through Shift-IR therefore produce a mix of both selections. A walk of several thousand steps with biased `tms` reaches the Pause and Exit2 loops and long shifts, and occasional resets land mid-scan. Directed runs of five high `tms` bits started from random states target the escape rule.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    TS_EX2D = 4'h0, TS_EX1D = 4'h1, TS_SHFD = 4'h2, TS_PAUD = 4'h3,
    TS_SELI = 4'h4, TS_UPDD = 4'h5, TS_CAPD = 4'h6, TS_SELD = 4'h7,
    TS_EX2I = 4'h8, TS_EX1I = 4'h9, TS_SHFI = 4'hA, TS_PAUI = 4'hB,
    TS_IDLE = 4'hC, TS_UPDI = 4'hD, TS_CAPI = 4'hE, TS_RST  = 4'hF
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      TS_RST:  n = m ? TS_RST  : TS_IDLE;
      TS_IDLE: n = m ? TS_SELD : TS_IDLE;
      TS_SELD: n = m ? TS_SELI : TS_CAPD;
      TS_CAPD: n = m ? TS_EX1D : TS_SHFD;
      TS_SHFD: n = m ? TS_EX1D : TS_SHFD;
      TS_EX1D: n = m ? TS_UPDD : TS_PAUD;
      TS_PAUD: n = m ? TS_EX2D : TS_PAUD;
      TS_EX2D: n = m ? TS_UPDD : TS_SHFD;
      TS_UPDD: n = m ? TS_SELD : TS_IDLE;
      TS_SELI: n = m ? TS_RST  : TS_CAPI;
      TS_CAPI: n = m ? TS_EX1I : TS_SHFI;
      TS_SHFI: n = m ? TS_EX1I : TS_SHFI;
      TS_EX1I: n = m ? TS_UPDI : TS_PAUI;
      TS_PAUI: n = m ? TS_EX2I : TS_PAUI;
      TS_EX2I: n = m ? TS_UPDI : TS_SHFI;
      TS_UPDI: n = m ? TS_SELD : TS_IDLE;
      default: n = TS_RST;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck) begin
    if (!trst_n) state <= TS_RST;
    else         state <= tap_next(state, tms);
  end

  // run of high tms edges, saturating at five (checking aid)
  logic [2:0] hi_run;
  always_ff @(posedge tck) begin
    if (!trst_n)         hi_run <= 3'd5;
    else if (!tms)       hi_run <= 3'd0;
    else if (hi_run != 3'd5) hi_run <= hi_run + 3'd1;
  end

  // R2
  five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_run == 3'd5) |-> (state == TS_RST));

  // R1
  leave_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RST && !tms) |=> (state == TS_IDLE));

  // R4
  shift_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ((state == TS_SHFD || state == TS_PAUD) && !tms) |=> $stable(state));

  // R4
  update_exit_chk: assert property (@(posedge tck) disable iff (!trst_n)
    ((state == TS_UPDI || state == TS_UPDD) && tms) |=> (state == TS_SELD));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int             IR_W   = 4,
  parameter logic [IR_W-1:0] IR_CAP = 4'b0001
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic            ir_lsb,
  output logic [IR_W-1:0] insn
);

  logic [IR_W-1:0] sr;

  always_ff @(posedge tck) begin
    if (!trst_n) begin
      sr   <= IR_CAP;
      insn <= '1;
    end else begin
      case (state)
        TS_CAPI: sr <= IR_CAP;
        TS_SHFI: sr <= {tdi, sr[IR_W-1:1]};
        default: sr <= sr;
      endcase
      if (state == TS_RST)       insn <= '1;
      else if (state == TS_UPDI) insn <= sr;
    end
  end

  assign ir_lsb = sr[0];

  // R5
  cap_load_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAPI) |=> (sr == IR_CAP));

  // R5
  ir_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_SHFI) |=> (sr[IR_W-1] == $past(tdi)));

  // R6
  insn_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !(state == TS_UPDI || state == TS_RST) |=> $stable(insn));

endmodule

// File: rtl/tap_dr_route.sv
module tap_dr_route
  import tap_pkg::*;
#(
  parameter int IR_W   = 4,
  parameter int NUM_DR = 4
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  tap_state_e        state,
  input  logic [IR_W-1:0]   insn,
  input  logic [NUM_DR-1:0] dr_tdo,
  output logic [NUM_DR-1:0] dr_sel,
  output logic              dr_capture,
  output logic              dr_shift,
  output logic              dr_update,
  output logic              dr_serial
);

  logic byp;

  for (genvar g = 0; g < NUM_DR; g++) begin : g_dec
    assign dr_sel[g] = (insn == IR_W'(g));
  end

  assign dr_capture = (state == TS_CAPD);
  assign dr_shift   = (state == TS_SHFD);
  assign dr_update  = (state == TS_UPDD);

  always_ff @(posedge tck) begin
    if (!trst_n)         byp <= 1'b0;
    else if (dr_capture) byp <= 1'b0;
    else if (dr_shift)   byp <= tdi;
  end

  always_comb begin
    dr_serial = byp;
    for (int k = 0; k < NUM_DR; k++)
      if (dr_sel[k]) dr_serial = dr_tdo[k];
  end

  // R7
  sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(dr_sel));

  // R8
  byp_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAPD) |=> (byp == 1'b0));

  // R8
  byp_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_SHFD) |=> (byp == $past(tdi)));

  // R9
  cap_next_chk: assert property (@(posedge tck) disable iff (!trst_n)
    dr_capture |=> (dr_shift || state == TS_EX1D));

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int              IR_W   = 4,
  parameter int              NUM_DR = 4,
  parameter logic [IR_W-1:0] IR_CAP = 4'b0001
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [NUM_DR-1:0] dr_tdo,
  output logic              tdo,
  output logic              tdo_oe,
  output logic [NUM_DR-1:0] dr_sel,
  output logic              dr_capture,
  output logic              dr_shift,
  output logic              dr_update,
  output logic [IR_W-1:0]   insn,
  output logic [3:0]        tap_state
);

  tap_state_e state;
  logic       ir_lsb;
  logic       dr_serial;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  tap_ir #(.IR_W(IR_W), .IR_CAP(IR_CAP)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_lsb(ir_lsb), .insn(insn)
  );

  tap_dr_route #(.IR_W(IR_W), .NUM_DR(NUM_DR)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .insn(insn),
    .dr_tdo(dr_tdo), .dr_sel(dr_sel), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .dr_serial(dr_serial)
  );

  assign tap_state = state;

  always_ff @(negedge tck) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == TS_SHFI) || (state == TS_SHFD);
      tdo    <= (state == TS_SHFI) ? ir_lsb : dr_serial;
    end
  end

  // R10
  oe_match_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == TS_SHFI || state == TS_SHFD));

endmodule

// File: tb/sim_tap_port.sv
module sim_tap_port;

  localparam int IR_W   = 4;
  localparam int NUM_DR = 4;

  logic              tck = 1'b0;
  logic              trst_n = 1'b0;
  logic              tms = 1'b1;
  logic              tdi = 1'b0;
  logic [NUM_DR-1:0] dr_tdo = '0;
  logic              tdo, tdo_oe, dr_capture, dr_shift, dr_update;
  logic [NUM_DR-1:0] dr_sel;
  logic [IR_W-1:0]   insn;
  logic [3:0]        tap_state;

  int errors = 0;
  int checks = 0;

  // bench reference state
  logic [3:0] m_st  = 4'hF;
  logic [3:0] m_ir  = 4'b0001;
  logic [3:0] m_act = 4'hF;
  logic       m_byp = 1'b0;

  always #5 tck = ~tck;

  tap_port #(.IR_W(IR_W), .NUM_DR(NUM_DR), .IR_CAP(4'b0001)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .dr_tdo(dr_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe), .dr_sel(dr_sel), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .insn(insn),
    .tap_state(tap_state)
  );

  // successor as [tms=0, tms=1] pairs
  function automatic logic [3:0] succ(input logic [3:0] s, input logic m);
    logic [7:0] pr;
    case (s)
      4'hF: pr = 8'hCF; 4'hC: pr = 8'hC7; 4'h7: pr = 8'h64; 4'h4: pr = 8'hEF;
      4'h6: pr = 8'h21; 4'h2: pr = 8'h21; 4'h1: pr = 8'h35; 4'h3: pr = 8'h30;
      4'h0: pr = 8'h25; 4'h5: pr = 8'hC7;
      4'hE: pr = 8'hA9; 4'hA: pr = 8'hA9; 4'h9: pr = 8'hBD; 4'hB: pr = 8'hB8;
      4'h8: pr = 8'hAD; 4'hD: pr = 8'hC7;
      default: pr = 8'hFF;
    endcase
    return m ? pr[3:0] : pr[7:4];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one tck period: drive, check falling-edge output, check after rising edge
  task automatic tick(input logic t, input logic d);
    logic exp_oe, exp_tdo;
    tms = t; tdi = d;
    @(negedge tck); #1;
    exp_oe = trst_n && (m_st == 4'hA || m_st == 4'h2);
    chk(tdo_oe == exp_oe, "R10", "tdo_oe", tdo_oe, exp_oe);
    if (exp_oe) begin
      if (m_st == 4'hA) begin
        exp_tdo = m_ir[0];
        chk(tdo == exp_tdo, "R5", "ir tdo", tdo, exp_tdo);
      end else if (m_act < NUM_DR) begin
        exp_tdo = dr_tdo[m_act];
        chk(tdo == exp_tdo, "R7", "dr tdo", tdo, exp_tdo);
      end else begin
        exp_tdo = m_byp;
        chk(tdo == exp_tdo, "R8", "bypass tdo", tdo, exp_tdo);
      end
    end
    if (!trst_n) begin
      m_st = 4'hF; m_act = 4'hF; m_ir = 4'b0001; m_byp = 1'b0;
    end else begin
      if (m_st == 4'hF)      m_act = 4'hF;
      else if (m_st == 4'hD) m_act = m_ir;
      if (m_st == 4'hE)      m_ir = 4'b0001;
      else if (m_st == 4'hA) m_ir = {d, m_ir[3:1]};
      if (m_st == 4'h6)      m_byp = 1'b0;
      else if (m_st == 4'h2) m_byp = d;
      m_st = succ(m_st, t);
    end
    @(posedge tck); #1;
    chk(tap_state == m_st, "R4", "state", tap_state, m_st);
    chk(insn == m_act, "R6", "insn", insn, m_act);
    chk(dr_sel == ((m_act < NUM_DR) ? (4'b1 << m_act) : 4'b0), "R7", "dr_sel",
        dr_sel, (m_act < NUM_DR) ? (4'b1 << m_act) : 0);
    chk({dr_capture, dr_shift, dr_update} ==
        {m_st == 4'h6, m_st == 4'h2, m_st == 4'h5}, "R9", "strobes",
        {dr_capture, dr_shift, dr_update},
        {m_st == 4'h6, m_st == 4'h2, m_st == 4'h5});
  endtask

  task automatic load_insn(input logic [3:0] code);
    tick(0, 0); tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) tick(i == 3, code[i]);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1149));
    // R3 reset state
    for (int i = 0; i < 3; i++) tick(1, 0);
    chk(tap_state == 4'hF, "R3", "reset state", tap_state, 4'hF);
    chk(insn == 4'hF, "R3", "reset insn", insn, 4'hF);
    chk(tdo_oe == 1'b0, "R3", "reset oe", tdo_oe, 0);
    trst_n = 1'b1;
    tick(1, 0);
    chk(tap_state == 4'hF, "R1", "reset hold", tap_state, 4'hF);
    tick(0, 0);
    chk(tap_state == 4'hC, "R1", "to idle", tap_state, 4'hC);
    tick(1, 0); tick(1, 0); tick(1, 0);
    chk(tap_state == 4'hF, "R1", "select-ir escape", tap_state, 4'hF);

    // R5 capture pattern shifted out; R7 code 2 selects DR2
    load_insn(4'd2);
    chk(insn == 4'd2, "R6", "insn after update", insn, 2);
    chk(dr_sel == 4'b0100, "R7", "dr_sel code 2", dr_sel, 4'b0100);
    // DR scan through DR2 with pause loop
    dr_tdo = 4'b0100;
    tick(1, 0); tick(0, 0); tick(0, 1); tick(0, 0); tick(1, 1);
    tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 1); tick(1, 0); tick(1, 0);
    // bypass through code 9
    load_insn(4'd9);
    chk(dr_sel == 4'b0000, "R7", "bypass select", dr_sel, 0);
    tick(1, 0); tick(0, 0);
    for (int i = 0; i < 6; i++) tick(i == 5, i[0]);
    tick(1, 0); tick(0, 0);

    // R2 escape from random states
    for (int r = 0; r < 40; r++) begin
      int n = 1 + ($urandom % 12);
      for (int i = 0; i < n; i++) tick(($urandom % 3) == 0, $urandom % 2);
      for (int i = 0; i < 5; i++) tick(1, $urandom % 2);
      chk(tap_state == 4'hF, "R2", "five ones", tap_state, 4'hF);
      tick(0, 0);
    end

    // random walk with occasional reset
    for (int i = 0; i < 6000; i++) begin
      dr_tdo = 4'($urandom);
      trst_n = (($urandom % 250) != 0);
      tick(($urandom % 100) < 30, $urandom % 2);
      if (!trst_n)
        chk(tap_state == 4'hF && insn == 4'hF, "R3", "mid-run reset",
            {tap_state, insn}, 8'hFF);
    end
    trst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule